// File: doc/BRIEF.md
# Barrel Shifter with Flag Rules

This block is a purely combinational 32-bit shift and rotate unit meant to sit beside an integer ALU. In one pass it produces a shifted or rotated operand together with new negative, zero and carry flags. The overflow flag is returned untouched. The shift distance comes from one of two places. It can be a small immediate field held in the instruction word, or the low byte of a register value. The two paths treat the degenerate distances differently, so the same numeric amount can give different results depending on where it came from.

On the immediate path, a distance of zero means "no shift" for a left shift. For the two right shifts it means a full-width shift. A rotate cannot be requested on this path. On the register path, any byte value from 0 to 255 is accepted. Zero leaves both the operand and the carry alone. Distances equal to the word width and beyond it follow fixed carry rules. A rotate uses only the distance modulo the word width.

Top module: `shf_unit`

## Requirements
- R1: `kind` selects the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `use_reg`=1 takes the distance n from `reg_amt` (8 bits); `use_reg`=0 takes it from `imm_amt` (5 bits). For 1 ≤ n ≤ 31, a left shift gives `opnd << n` with carry `opnd[32-n]`. Both right shifts give the shifted value with carry `opnd[n-1]`, and the arithmetic one fills from `opnd[31]`.
- R2: Immediate path, left shift by 0: the result equals `opnd` and the carry equals `c_in`.
- R3: Immediate path, logical right by 0 acts as a 32-bit shift: the result is 0 and the carry is `opnd[31]`.
- R4: Immediate path, arithmetic right by 0 acts as a 32-bit shift: every result bit equals `opnd[31]`, and so does the carry.
- R5: Immediate path with `kind`=11 leaves the result equal to `opnd` and the carry equal to `c_in`.
- R6: Register path with `reg_amt`=0, for every `kind`: the result equals `opnd` and the carry equals `c_in`.
- R7: Register path with a distance of exactly 32: a left shift gives 0 with carry `opnd[0]`, and a logical right shift gives 0 with carry `opnd[31]`.
- R8: Register path, left or logical right shift with a distance from 33 to 255: the result is 0 and the carry is 0.
- R9: Register path, arithmetic right shift with a distance from 32 to 255: every result bit equals `opnd[31]`, and so does the carry.
- R10: Register path rotate with nonzero `reg_amt`: let r = `reg_amt[4:0]`. If r = 0, the result is `opnd` and the carry is `opnd[31]`. Otherwise the result is `opnd` rotated right by r and the carry is `opnd[r-1]`.
- R11: In every case `n_out` equals bit 31 of the result, and `z_out` is 1 exactly when the result is zero.
- R12: `v_out` always equals `v_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand to shift or rotate |
| imm_amt | input | 5 | Distance from the immediate field |
| reg_amt | input | 8 | Distance from the low byte of a register |
| kind | input | 2 | Operation select (see R1) |
| use_reg | input | 1 | 1 = take the distance from `reg_amt` |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Shifted or rotated value |
| c_out | output | 1 | New carry flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | Overflow flag passed through |

## Verification
In a single evaluation, the carry rule and the result rule can both fall into a boundary case at once. One example is a register distance of exactly 32, where the carry must come from bit 0 or bit 31 at the same moment the result must collapse to zero. Another is a rotate by a multiple of 32, where the result is held while the carry is still rewritten. The bench reaches these cases by sweeping every register distance from 0 to 255 and every immediate distance from 0 to 31, over all four kinds, both carry inputs and a set of operands with distinct edge bits. It judges each vector against a bit-by-bit model that checks result, carry, N, Z and V together.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

endpackage

// File: rtl/shf_amount_sel.sv
// Picks the shift distance and folds the path-specific degenerate cases into a
// single linear amount, a hold request and a rotate request.
module shf_amount_sel
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = $clog2(DATA_W),
  parameter int unsigned REG_AMT_W = 8
) (
  input  logic                 use_reg,
  input  logic [1:0]           kind,
  input  logic [IMM_W-1:0]     imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  output logic [REG_AMT_W-1:0] lin_amt,
  output logic [IMM_W-1:0]     rot_amt,
  output logic                 hold,
  output logic                 is_rot
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  logic imm_zero;
  logic reg_zero;

  assign imm_zero = (imm_amt == '0);
  assign reg_zero = (reg_amt == '0);

  always_comb begin
    lin_amt = '0;
    rot_amt = '0;
    hold    = 1'b0;
    is_rot  = 1'b0;
    if (use_reg) begin
      lin_amt = reg_amt;
      rot_amt = reg_amt[IMM_W-1:0];
      hold    = reg_zero;
      is_rot  = (shift_kind_e'(kind) == SHK_ROR);
    end else begin
      unique case (shift_kind_e'(kind))
        SHK_LSL: begin
          lin_amt = REG_AMT_W'(imm_amt);
          hold    = imm_zero;
        end
        SHK_LSR, SHK_ASR: begin
          lin_amt = imm_zero ? FULL_AMT : REG_AMT_W'(imm_amt);
        end
        default: begin
          hold = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/shf_datapath.sv
// Result and carry generation. Linear shifts are done on a one-bit-wider word
// so the carry falls out of the same shift; the rotate is a log-depth barrel.
module shf_datapath
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = $clog2(DATA_W),
  parameter int unsigned REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]    opnd,
  input  logic [1:0]           kind,
  input  logic [REG_AMT_W-1:0] lin_amt,
  input  logic [IMM_W-1:0]     rot_amt,
  input  logic                 hold,
  input  logic                 is_rot,
  input  logic                 c_in,
  output logic [DATA_W-1:0]    result,
  output logic                 c_out
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  // {carry, value}: the bit pushed out past the top lands in the extra MSB.
  function automatic logic [DATA_W:0] left_ext(input logic [DATA_W-1:0] v,
                                               input logic [REG_AMT_W-1:0] n);
    return {1'b0, v} << n;
  endfunction

  // {value, carry}: the last bit pushed out past bit 0 lands in the extra LSB.
  function automatic logic [DATA_W:0] right_ext(input logic [DATA_W-1:0] v,
                                                input logic [REG_AMT_W-1:0] n);
    return {v, 1'b0} >> n;
  endfunction

  // Arithmetic variant, distance saturated at the word width.
  function automatic logic [DATA_W:0] arith_ext(input logic [DATA_W-1:0] v,
                                                input logic [REG_AMT_W-1:0] n);
    logic [REG_AMT_W-1:0] s;
    logic signed [DATA_W:0] w;
    s = (n > FULL_AMT) ? FULL_AMT : n;
    w = $signed({v, 1'b0});
    return w >>> s;
  endfunction

  // Barrel rotator: stage k rotates right by 2**k when rot_amt[k] is set.
  logic [DATA_W-1:0] rot_stage [0:IMM_W];
  assign rot_stage[0] = opnd;

  for (genvar k = 0; k < IMM_W; k++) begin : g_rot
    localparam int unsigned DIST = 1 << k;
    assign rot_stage[k+1] = rot_amt[k]
                          ? {rot_stage[k][DIST-1:0], rot_stage[k][DATA_W-1:DIST]}
                          : rot_stage[k];
  end

  logic [DATA_W-1:0] rot_res;
  logic [DATA_W:0]   lsl_w;
  logic [DATA_W:0]   lsr_w;
  logic [DATA_W:0]   asr_w;

  assign rot_res = rot_stage[IMM_W];
  assign lsl_w   = left_ext(opnd, lin_amt);
  assign lsr_w   = right_ext(opnd, lin_amt);
  assign asr_w   = arith_ext(opnd, lin_amt);

  always_comb begin
    result = opnd;
    c_out  = c_in;
    if (hold) begin
      result = opnd;
      c_out  = c_in;
    end else if (is_rot) begin
      result = rot_res;
      c_out  = rot_res[DATA_W-1];
    end else begin
      unique case (shift_kind_e'(kind))
        SHK_LSL: {c_out, result} = lsl_w;
        SHK_LSR: {result, c_out} = lsr_w;
        SHK_ASR: {result, c_out} = asr_w;
        default: begin
          result = opnd;
          c_out  = c_in;
        end
      endcase
    end
  end

endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              v_in,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out
);

  assign n_out = result[DATA_W-1];
  assign z_out = ~|result;
  assign v_out = v_in;

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = $clog2(DATA_W),
  parameter int unsigned REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]    opnd,
  input  logic [IMM_W-1:0]     imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  input  logic [1:0]           kind,
  input  logic                 use_reg,
  input  logic                 c_in,
  input  logic                 v_in,
  output logic [DATA_W-1:0]    result,
  output logic                 c_out,
  output logic                 n_out,
  output logic                 z_out,
  output logic                 v_out
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  // Decoded events, named for the checks below.
  logic [REG_AMT_W-1:0] ev_lin_amt;
  logic [IMM_W-1:0]     ev_rot_amt;
  logic                 ev_hold;
  logic                 ev_rot;

  shf_amount_sel #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W)
  ) u_amt (
    .use_reg (use_reg),
    .kind    (kind),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .lin_amt (ev_lin_amt),
    .rot_amt (ev_rot_amt),
    .hold    (ev_hold),
    .is_rot  (ev_rot)
  );

  shf_datapath #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W)
  ) u_dp (
    .opnd    (opnd),
    .kind    (kind),
    .lin_amt (ev_lin_amt),
    .rot_amt (ev_rot_amt),
    .hold    (ev_hold),
    .is_rot  (ev_rot),
    .c_in    (c_in),
    .result  (result),
    .c_out   (c_out)
  );

  shf_flags #(.DATA_W(DATA_W)) u_flg (
    .result (result),
    .v_in   (v_in),
    .n_out  (n_out),
    .z_out  (z_out),
    .v_out  (v_out)
  );

  logic reg_lsl_or_lsr;
  logic reg_asr;
  logic reg_ror;
  logic imm_lsr_zero;

  assign reg_lsl_or_lsr = use_reg && (shift_kind_e'(kind) == SHK_LSL || shift_kind_e'(kind) == SHK_LSR);
  assign reg_asr        = use_reg && (shift_kind_e'(kind) == SHK_ASR);
  assign reg_ror        = use_reg && (shift_kind_e'(kind) == SHK_ROR);
  assign imm_lsr_zero   = !use_reg && (shift_kind_e'(kind) == SHK_LSR) && (imm_amt == '0);

  always_comb begin
    // R6
    reg_zero_hold_chk: assert (!(use_reg && reg_amt == '0) || (result == opnd && c_out == c_in))
      else $error("register distance 0 altered operand or carry");
    // R8
    reg_overrun_clear_chk: assert (!(reg_lsl_or_lsr && reg_amt > FULL_AMT) || (result == '0 && !c_out))
      else $error("overrun shift left nonzero result or carry");
    // R9
    reg_sign_fill_chk: assert (!(reg_asr && reg_amt >= FULL_AMT)
                               || (result == {DATA_W{opnd[DATA_W-1]}} && c_out == opnd[DATA_W-1]))
      else $error("arithmetic overrun not sign filled");
    // R3
    imm_lsr_full_chk: assert (!imm_lsr_zero || (result == '0 && c_out == opnd[DATA_W-1]))
      else $error("immediate zero logical right not a full shift");
    // R10
    rot_carry_chk: assert (!(reg_ror && reg_amt != '0) || (c_out == result[DATA_W-1]))
      else $error("rotate carry differs from result top bit");
  end

endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd = '0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic [1:0]  kind = '0;
  logic        use_reg = 1'b0;
  logic        c_in = 1'b0;
  logic        v_in = 1'b0;
  logic [31:0] result;
  logic        c_out, n_out, z_out, v_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  shf_unit uut (
    .opnd(opnd), .imm_amt(imm_amt), .reg_amt(reg_amt), .kind(kind),
    .use_reg(use_reg), .c_in(c_in), .v_in(v_in), .result(result),
    .c_out(c_out), .n_out(n_out), .z_out(z_out), .v_out(v_out)
  );

  // Bit-by-bit reference model; tag names the requirement the vector exercises.
  task automatic model(input logic [31:0] op, input int k, input bit ur,
                       input int amt_in, input bit cin,
                       output logic [31:0] er, output logic ec, output string tag);
    int amt;
    amt = amt_in;
    er  = op;
    ec  = cin;
    tag = "R1";
    if (ur && amt == 0) begin
      tag = "R6";
    end else if (k == 0) begin
      if (amt == 0) tag = "R2";
      else begin
        for (int i = 0; i < 32; i++) er[i] = (i - amt >= 0) ? op[i - amt] : 1'b0;
        ec = (amt <= 32) ? op[32 - amt] : 1'b0;
        if (amt == 32) tag = "R7"; else if (amt > 32) tag = "R8";
      end
    end else if (k == 1 || k == 2) begin
      if (!ur && amt == 0) begin
        amt = 32;
        tag = (k == 1) ? "R3" : "R4";
      end else if (amt >= 32) begin
        tag = (k == 2) ? "R9" : ((amt == 32) ? "R7" : "R8");
      end
      for (int i = 0; i < 32; i++)
        er[i] = (i + amt < 32) ? op[i + amt] : ((k == 2) ? op[31] : 1'b0);
      if (amt <= 32) ec = op[amt - 1];
      else ec = (k == 2) ? op[31] : 1'b0;
    end else begin
      if (!ur) tag = "R5";
      else begin
        int r;
        tag = "R10";
        r = amt % 32;
        for (int i = 0; i < 32; i++) er[i] = op[(i + r) % 32];
        ec = (r == 0) ? op[31] : op[r - 1];
      end
    end
  endtask

  task automatic run_vec(input logic [31:0] op, input int k, input bit ur,
                         input int amt, input bit cin, input bit vin);
    logic [31:0] er;
    logic ec, en, ez;
    string tag;
    @(posedge clk);
    opnd    = op;
    kind    = 2'(k);
    use_reg = ur;
    imm_amt = ur ? 5'd0 : 5'(amt);
    reg_amt = ur ? 8'(amt) : 8'd0;
    c_in    = cin;
    v_in    = vin;
    model(op, k, ur, amt, cin, er, ec, tag);
    en = er[31];
    ez = (er == 32'h0);
    @(negedge clk);
    checks++;
    if (result !== er || c_out !== ec) begin
      errors++;
      $display("FAIL %s: op=%h kind=%0d reg=%0d amt=%0d cin=%0b got res=%h c=%0b exp res=%h c=%0b",
               tag, op, k, ur, amt, cin, result, c_out, er, ec);
    end else if (n_out !== en || z_out !== ez) begin
      errors++;
      $display("FAIL R11: op=%h kind=%0d amt=%0d got n=%0b z=%0b exp n=%0b z=%0b",
               op, k, amt, n_out, z_out, en, ez);
    end else if (v_out !== vin) begin
      errors++;
      $display("FAIL R12: got v=%0b exp v=%0b", v_out, vin);
    end
  endtask

  logic [31:0] ops [0:7];

  initial begin
    ops[0] = 32'h0000_0000; ops[1] = 32'hFFFF_FFFF;
    ops[2] = 32'h8000_0000; ops[3] = 32'h0000_0001;
    ops[4] = 32'hA5A5_5A5A; ops[5] = 32'h5A5A_A5A5;
    ops[6] = 32'h8000_0001; ops[7] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: all-zero inputs give a zero result with Z set (R2, R11).
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || c_out !== 1'b0 || z_out !== 1'b1 || n_out !== 1'b0 || v_out !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle got res=%h c=%0b z=%0b exp res=0 c=0 z=1", result, c_out, z_out);
    end
    for (int o = 0; o < 8; o++)
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 2; c++) begin
          for (int a = 0; a < 32; a++)
            run_vec(ops[o], k, 1'b0, a, c[0], a[0] ^ c[0]);
          for (int a = 0; a < 256; a++)
            run_vec(ops[o], k, 1'b1, a, c[0], a[1] ^ c[0]);
        end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule